// File: doc/BRIEF.md
# Serial EEPROM Read Target on a Two-Wire Bus

This block is the target side of a two-wire serial memory bus. It models the read behaviour of a 32K x 8 serial EEPROM. SCL and SDA are sampled by a faster system clock. The block drives SDA only through an open-drain enable: when the enable is high, the line is pulled low.

A bus master first addresses the device with a control byte. It can then load the block's persistent 15-bit address pointer with a write-direction transfer that carries two address bytes. Data is read back with a read-direction control byte. Three kinds of read are supported:
- a read at the current pointer, with no address bytes;
- a random read, where a repeated START follows the address bytes;
- a sequential read, where the master acknowledges each byte to get the next one.

The pointer advances after every byte that is sent, and it wraps from the top of memory to zero. The storage is an internal register array that reset fills with a computed pattern.

Top module: `i2c_rom_target`

## Requirements
- R1: The block acknowledges a control byte only when its top nibble is 4'b1010 and bits [3:1] equal `strap_i`. Acknowledging means holding SDA low through the ninth clock. On any other control byte, SDA stays released until the next START.
- R2: A control byte with bit 0 = 0 is followed by a high address byte and a low address byte. The block acknowledges all three bytes and loads the pointer with {high[6:0], low}. Bit 7 of the high byte is ignored.
- R3: A repeated START after the address bytes, followed by a control byte with bit 0 = 1, returns the byte stored at the loaded address.
- R4: Data is sent MSB first. The SDA enable changes only while SCL is low.
- R5: When the master acknowledges a data byte, the block sends the byte at the next address.
- R6: When the master does not acknowledge a data byte, the block releases SDA and sends nothing more until the next START or STOP.
- R7: After a byte at address n has been read, a read with no address bytes returns the byte at n + 1.
- R8: When the master acknowledges the byte read from address 7FFF, the pointer wraps to 0000 and the read continues from there.
- R9: A START or STOP at any point returns the block to control-byte receive or to idle, and leaves the pointer unchanged.
- R10: After reset, the byte at address a is ((a mod 256) * 37 + 0x5A) mod 256. Addresses alias on their low 8 bits (DEPTH_W = 8).
- R11: During and right after reset, SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, as seen on the wire |
| strap_i | input | 3 | Chip-select strap compared with control byte bits [3:1] |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The hardest state to reach is the pointer wrap. The pointer has to sit at 7FFF while the master acknowledges. Without that acknowledgement, the byte at 7FFF ends a transfer instead of leading into address 0000. The bench loads the pointer near the top of memory and then runs one unbroken sequential read of 300 bytes across the boundary. That read also sweeps every array location.

An aborted address write, which must leave the pointer untouched, is produced by cutting the write short with a repeated START and, separately, with a STOP. The bench then confirms the old pointer with a current-address read.

// File: rtl/i2c_rom_pkg.sv
package i2c_rom_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CTRL, ST_CTRL_ACK, ST_AHI, ST_AHI_ACK,
    ST_ALO, ST_ALO_ACK, ST_TX, ST_TX_ACK, ST_IGNORE
  } st_e;
  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_o      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_rom_array.sv
module i2c_rom_array #(
  parameter int         DEPTH_W = 8,
  parameter logic [7:0] MULT    = 8'd37,
  parameter logic [7:0] SEED    = 8'h5A
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DEPTH_W-1:0] addr_i,
  output logic [7:0]         data_o
);
  localparam int DEPTH = 1 << DEPTH_W;
  logic [7:0] mem [DEPTH];

  // preload on reset; no write port in this block
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i * int'(MULT) + int'(SEED));
    end else begin
      mem <= mem;
    end
  end

  assign data_o = mem[addr_i];
endmodule

// File: rtl/i2c_rd_ctrl.sv
module i2c_rd_ctrl
  import i2c_rom_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [2:0]        strap_i,
  input  logic [7:0]        rd_data_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] ptr_o,
  output st_e               state_o
);
  localparam int HI_W = ADDR_W - 8;

  st_e               state;
  logic [3:0]        cnt;
  logic [7:0]        sh;
  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] ptr;
  logic              rw_q, mack_q, oe_q;
  logic              rx_done;

  assign rx_done = scl_fall_i && (cnt == 4'd8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      hi_q   <= '0;
      ptr    <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (start_i) begin
      state <= ST_CTRL;
      cnt   <= '0;
      oe_q  <= 1'b0;
    end else if (stop_i) begin
      state <= ST_IDLE;
      cnt   <= '0;
      oe_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_CTRL: begin
          if (scl_rise_i) begin
            sh  <= {sh[6:0], sda_s_i};
            cnt <= cnt + 4'd1;
          end else if (rx_done) begin
            cnt <= '0;
            if (sh[7:4] == DEV_CODE && sh[3:1] == strap_i) begin
              rw_q  <= sh[0];
              oe_q  <= 1'b1;
              state <= ST_CTRL_ACK;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_AHI: begin
          if (scl_rise_i) begin
            sh  <= {sh[6:0], sda_s_i};
            cnt <= cnt + 4'd1;
          end else if (rx_done) begin
            cnt   <= '0;
            hi_q  <= sh[HI_W-1:0];
            oe_q  <= 1'b1;
            state <= ST_AHI_ACK;
          end
        end
        ST_ALO: begin
          if (scl_rise_i) begin
            sh  <= {sh[6:0], sda_s_i};
            cnt <= cnt + 4'd1;
          end else if (rx_done) begin
            cnt   <= '0;
            ptr   <= {hi_q, sh};
            oe_q  <= 1'b1;
            state <= ST_ALO_ACK;
          end
        end
        ST_CTRL_ACK: begin
          if (scl_fall_i) begin
            cnt <= '0;
            if (rw_q) begin
              sh    <= rd_data_i;
              ptr   <= ptr + 1'b1;
              oe_q  <= ~rd_data_i[7];
              state <= ST_TX;
            end else begin
              oe_q  <= 1'b0;
              state <= ST_AHI;
            end
          end
        end
        ST_AHI_ACK: if (scl_fall_i) begin
          oe_q  <= 1'b0;
          state <= ST_ALO;
        end
        ST_ALO_ACK: if (scl_fall_i) begin
          oe_q  <= 1'b0;
          state <= ST_IGNORE;
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (cnt == 4'd7) begin
              oe_q  <= 1'b0;
              state <= ST_TX_ACK;
            end else begin
              sh   <= {sh[6:0], 1'b0};
              oe_q <= ~sh[6];
              cnt  <= cnt + 4'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i) begin
            mack_q <= ~sda_s_i;
          end else if (scl_fall_i) begin
            cnt <= '0;
            if (mack_q) begin
              sh    <= rd_data_i;
              ptr   <= ptr + 1'b1;
              oe_q  <= ~rd_data_i[7];
              state <= ST_TX;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        default: ;  // idle / ignore: wait for START
      endcase
    end
  end

  assign sda_oe_o = oe_q;
  assign ptr_o    = ptr;
  assign state_o  = state;
endmodule

// File: rtl/i2c_rom_target.sv
module i2c_rom_target
  import i2c_rom_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DEPTH_W = 8,
  parameter int STAGES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        rd_data;
  st_e               state;

  i2c_line_sync #(.STAGES(STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_rom_array #(.DEPTH_W(DEPTH_W)) u_mem (
    .clk_i, .rst_ni,
    .addr_i(ptr[DEPTH_W-1:0]),
    .data_o(rd_data)
  );

  i2c_rd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni,
    .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .strap_i, .rd_data_i(rd_data),
    .sda_oe_o, .ptr_o(ptr), .state_o(state)
  );
endmodule

// File: rtl/i2c_rom_target_chk.sv
module i2c_rom_target_chk
  import i2c_rom_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input logic              sda_oe_o,
  input logic [ADDR_W-1:0] ptr,
  input st_e               state
);
  a_r4_oe_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_s));

  a_r1_ignore_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_IGNORE |-> !sda_oe_o);

  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_IDLE |-> !sda_oe_o);

  a_r9_start_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> state == ST_CTRL);

  a_r9_stop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_det && !start_det) |=> state == ST_IDLE);

  a_r9_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det || stop_det) |=> ptr == $past(ptr));

  a_r5_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(ptr) && $past(state) != ST_ALO) |-> ptr == ADDR_W'($past(ptr) + 1'b1));

  a_r8_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(ptr) && $past(state) != ST_ALO && $past(ptr) == {ADDR_W{1'b1}}) |-> ptr == '0);
endmodule

bind i2c_rom_target i2c_rom_target_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe_o(sda_oe_o), .ptr(ptr), .state(state)
);

// File: tb/tb_i2c_rom_target.sv
module tb_i2c_rom_target;
  localparam int Q = 5;
  localparam logic [2:0] STRAP = 3'd5;

  logic clk = 1'b0, rst_ni = 1'b0, scl = 1'b1, msda = 1'b1;
  logic sda_oe;
  logic bus;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;
  assign bus = msda & ~sda_oe;

  i2c_rom_target dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(bus),
    .strap_i(STRAP), .sda_oe_o(sda_oe)
  );

  function automatic logic [7:0] exp_byte(input int a);
    return 8'(((a & 255) * 37 + 90) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    msda = 1'b1; wq(); scl = 1'b1; wq(); msda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    msda = 1'b0; wq(); scl = 1'b1; wq(); msda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    msda = 1'b1; wq(); scl = 1'b1; wq(); ack = !bus; wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    d = '0;
    for (int i = 0; i < 8; i++) begin
      msda = 1'b1; wq(); scl = 1'b1; wq(); d = {d[6:0], bus}; wq(); scl = 1'b0; wq();
    end
    msda = !mack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic set_ptr(input int a);
    bit ack;
    i2c_start();
    send_byte({4'hA, STRAP, 1'b0}, ack); check(ack, "R2 ctrl-write ack", ack, 1);
    send_byte(8'(a >> 8), ack);          check(ack, "R2 addr-high ack", ack, 1);
    send_byte(8'(a), ack);               check(ack, "R2 addr-low ack", ack, 1);
  endtask

  task automatic read_one(input int exp_addr, input string req);
    bit ack;
    logic [7:0] d;
    i2c_start();
    send_byte({4'hA, STRAP, 1'b1}, ack); check(ack, req, ack, 1);
    recv_byte(1'b0, d);
    check(d == exp_byte(exp_addr), req, d, exp_byte(exp_addr));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    int ptr_m;
    int addrs [5] = '{32'h0000, 32'h0013, 32'h1234, 32'h7FFE, 32'h80FF};

    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R11 oe in reset", sda_oe, 0);
    rst_ni = 1'b1;
    wq();
    check(sda_oe == 1'b0, "R11 oe after reset", sda_oe, 0);

    // R1: chip-select sweep; only the strapped value answers
    ptr_m = 0;
    for (int cs = 0; cs < 8; cs++) begin
      i2c_start();
      send_byte({4'hA, 3'(cs), 1'b1}, ack);
      check(ack == (cs == int'(STRAP)), "R1 select ack", ack, cs == int'(STRAP));
      recv_byte(1'b0, d);
      if (cs == int'(STRAP)) begin
        check(d == exp_byte(ptr_m), "R7 current read after reset", d, exp_byte(ptr_m));
        ptr_m++;
      end else begin
        check(d == 8'hFF, "R1 silent after mismatch", d, 8'hFF);
      end
      i2c_stop();
    end
    i2c_start();
    send_byte({4'hB, STRAP, 1'b1}, ack);
    check(!ack, "R1 wrong device code", ack, 0);
    i2c_stop();

    // R2 R3 R10 random reads, R7 follow-on current read, R6 silence after NACK
    foreach (addrs[k]) begin
      set_ptr(addrs[k]);
      read_one(addrs[k] & 32'h7FFF, "R3 random read");
      recv_byte(1'b0, d);
      check(d == 8'hFF, "R6 released after nack", d, 8'hFF);
      i2c_stop();
      read_one((addrs[k] + 1) & 32'h7FFF, "R7 next address");
      i2c_stop();
    end

    // R5 R8 R10 sequential read across 7FFF -> 0000
    set_ptr(32'h7F80);
    i2c_start();
    send_byte({4'hA, STRAP, 1'b1}, ack);
    check(ack, "R5 read ctrl ack", ack, 1);
    for (int i = 0; i < 300; i++) begin
      recv_byte(i != 299, d);
      check(d == exp_byte((32'h7F80 + i) & 32'h7FFF), "R5 R8 R10 sequential byte",
            d, exp_byte((32'h7F80 + i) & 32'h7FFF));
    end
    i2c_stop();
    read_one((32'h7F80 + 300) & 32'h7FFF, "R8 pointer after wrap");
    i2c_stop();

    // R9: aborted address writes leave the pointer alone
    set_ptr(32'h0040);
    i2c_stop();
    i2c_start();
    send_byte({4'hA, STRAP, 1'b0}, ack); check(ack, "R9 ctrl ack", ack, 1);
    send_byte(8'h12, ack);               check(ack, "R9 hi ack", ack, 1);
    read_one(32'h0040, "R9 repeated start aborts write");
    i2c_stop();
    i2c_start();
    send_byte({4'hA, STRAP, 1'b0}, ack); check(ack, "R9 ctrl ack", ack, 1);
    i2c_stop();
    read_one(32'h0041, "R9 stop aborts write");
    i2c_stop();
    wq();
    check(sda_oe == 1'b0, "R6 idle after stop", sda_oe, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule